// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block sits at the home node of a distributed shared memory and serves every coherence request that targets a line the node owns. Each accepted request is handled as one transaction. The controller reads the line's directory entry and the result of probing the home node's own caches and victim buffer. It then sends one response message and, where needed, a train of invalidates to the other sharers. Finally it writes the new directory entry back.

A directory entry holds a two-bit state, a sharer bit-vector with one bit per node, and an owner node number. A requester that wants to write a shared line receives an exclusive grant. The grant carries the number of invalidate acknowledgements the requester must collect before it may modify the line. Each invalidate is a separate outbound message with its own destination node, and it leaves through the same valid/ready channel as the response. The request channel stays closed until the last message of the transaction has been taken.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1 and `msg_valid` and `dir_wr_en` are 0.
- R2: A read (op 0) on a Local (state 0) or Shared (state 1) line, or on an Exclusive (state 2) line owned by the requester, answers with data (type 0) to the requester. The entry becomes Shared. Its sharer vector is the previous vector (taken only when the line was Shared) plus the requester's bit, and the owner field takes the requester.
- R3: A read on an Exclusive line owned by another node sends a read forward (type 4) to that owner. The entry becomes Shared with exactly the owner's and the requester's bits set.
- R4: A read-for-modify (op 1) on a Shared line, with `probe_hit` low, answers with an exclusive grant (type 1). The grant's count equals the number of sharers other than the requester. It is followed by one invalidate (type 6, count 0) to each of those sharers in ascending node order. No invalidate goes to the requester.
- R5: A read-for-modify on a Local line, or on an Exclusive line that the requester owns, answers with a grant of count 0. On an Exclusive line owned by another node it sends a modify forward (type 5) to the old owner. In every one of these cases the directory is written exactly once and the entry becomes Exclusive owned by the requester.
- R6: A read-for-modify with `probe_hit` high answers with a negative acknowledgement (type 7) and leaves the directory unwritten.
- R7: A shared-to-dirty upgrade (op 2) on a Shared line whose sharer vector contains the requester, with `probe_hit` low, answers with upgrade success (type 2). Its count equals the other sharers, and invalidates follow as in R4. The entry becomes Exclusive owned by the requester.
- R8: Any other upgrade gets upgrade failure (type 3) and leaves the directory unwritten. This covers a requester that is not a sharer, a line that is not Shared, and a high `probe_hit`.
- R9: A line in Incoherent (state 3), or a request with op 3, gets a negative acknowledgement (type 7) and leaves the directory unwritten.
- R10: From acceptance until its last message is taken, `req_ready` stays 0. While `msg_valid` is 1 and `msg_ready` is 0, the message type, destination and count hold their values.
- R11: Every directory write that sets Exclusive has exactly one sharer bit set, and that bit is the owner's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and taking a request |
| req_op | input | 2 | 0 read, 1 read-for-modify, 2 shared-to-dirty upgrade |
| req_src | input | NODE_W | Requesting node |
| req_addr | input | ADDR_W | Line address |
| probe_hit | input | 1 | Home caches or victim buffer hold a newer copy, sampled with the request |
| dir_rd_addr | output | ADDR_W | Directory read address, same-cycle read |
| dir_rd_state | input | 2 | Directory state read |
| dir_rd_sharers | input | NODES | Sharer vector read |
| dir_rd_owner | input | NODE_W | Owner read |
| dir_wr_en | output | 1 | Directory write strobe |
| dir_wr_addr | output | ADDR_W | Directory write address |
| dir_wr_state | output | 2 | New state |
| dir_wr_sharers | output | NODES | New sharer vector |
| dir_wr_owner | output | NODE_W | New owner |
| msg_valid | output | 1 | Outbound message present |
| msg_ready | input | 1 | Network takes the message |
| msg_type | output | 3 | Message code per R2 to R9 |
| msg_dest | output | NODE_W | Destination node |
| msg_count | output | NODE_W+1 | Acknowledgement count |
| msg_addr | output | ADDR_W | Line address of the transaction |

## Verification
The bench builds the controller with eight nodes and a four-bit address. With eight nodes, a full sharer vector drives the acknowledgement count to its largest value, seven, and produces a seven-message invalidate train. The sixteen-line address space is small enough that the single-holder rule for Exclusive entries can be swept over every line after each transaction. Stalls on the message channel are exercised in the middle of an invalidate train.

// File: rtl/dhc_pkg.sv
// Shared encodings for the home-node coherence controller.
// Assumes: codes listed here are the ones seen on the ports.
package dhc_pkg;
    typedef enum logic [1:0] {
        DS_LOCAL  = 2'd0,
        DS_SHARED = 2'd1,
        DS_EXCL   = 2'd2,
        DS_INCOH  = 2'd3
    } dstate_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_RDMOD = 2'd1,
        OP_UPGR  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        MT_DATA    = 3'd0,
        MT_GRANT   = 3'd1,
        MT_UP_OK   = 3'd2,
        MT_UP_FAIL = 3'd3,
        MT_FWD_RD  = 3'd4,
        MT_FWD_RM  = 3'd5,
        MT_INVAL   = 3'd6,
        MT_NACK    = 3'd7
    } mtype_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RESP = 2'd1,
        PH_INV  = 2'd2
    } phase_e;
endpackage

// File: rtl/dhc_decide.sv
// Transaction decision: from the request, the directory entry and the
// local probe result, picks the response, the new entry and the set of
// nodes to invalidate. Purely combinational.
// Assumes: the sharer vector is meaningful only in Shared/Exclusive.
module dhc_decide
    import dhc_pkg::*;
#(
    parameter int NODES = 8,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int CNT_W  = NODE_W + 1
) (
    input  logic [1:0]        op,
    input  logic [NODE_W-1:0] src,
    input  logic [1:0]        st,
    input  logic [NODES-1:0]  sharers,
    input  logic [NODE_W-1:0] owner,
    input  logic              probe_hit,
    output logic [2:0]        rtype,
    output logic [NODE_W-1:0] rdest,
    output logic [CNT_W-1:0]  rcount,
    output logic              wr_en,
    output logic [1:0]        wr_state,
    output logic [NODES-1:0]  wr_sharers,
    output logic [NODES-1:0]  inv_mask
);
    logic [NODES-1:0] src_bit;
    logic [NODES-1:0] own_bit;
    logic [NODES-1:0] others;
    logic [CNT_W-1:0] n_others;

    // Count sharers other than the requester.
    always_comb begin
        src_bit  = NODES'(1) << src;
        own_bit  = NODES'(1) << owner;
        others   = sharers & ~src_bit;
        n_others = '0;
        for (int i = 0; i < NODES; i++)
            n_others = n_others + CNT_W'(others[i]);
    end

    // Select response and directory update per op and state.
    always_comb begin
        rtype      = MT_NACK;
        rdest      = src;
        rcount     = '0;
        wr_en      = 1'b0;
        wr_state   = st;
        wr_sharers = sharers;
        inv_mask   = '0;
        if (st != DS_INCOH) begin
            case (op)
                OP_READ: begin
                    wr_en    = 1'b1;
                    wr_state = DS_SHARED;
                    if (st == DS_EXCL && owner != src) begin
                        rtype      = MT_FWD_RD;
                        rdest      = owner;
                        wr_sharers = src_bit | own_bit;
                    end else begin
                        rtype      = MT_DATA;
                        wr_sharers = ((st == DS_SHARED) ? sharers : '0) | src_bit;
                    end
                end
                OP_RDMOD: begin
                    if (!probe_hit) begin
                        wr_en      = 1'b1;
                        wr_state   = DS_EXCL;
                        wr_sharers = src_bit;
                        if (st == DS_EXCL && owner != src) begin
                            rtype = MT_FWD_RM;
                            rdest = owner;
                        end else begin
                            rtype = MT_GRANT;
                            if (st == DS_SHARED) begin
                                rcount   = n_others;
                                inv_mask = others;
                            end
                        end
                    end
                end
                OP_UPGR: begin
                    if (st == DS_SHARED && sharers[src] && !probe_hit) begin
                        rtype      = MT_UP_OK;
                        rcount     = n_others;
                        inv_mask   = others;
                        wr_en      = 1'b1;
                        wr_state   = DS_EXCL;
                        wr_sharers = src_bit;
                    end else begin
                        rtype = MT_UP_FAIL;
                    end
                end
                default: rtype = MT_NACK;
            endcase
        end
    end
endmodule

// File: rtl/dhc_inval_seq.sv
// Invalidate sequencer: holds the pending sharer set and emits the
// lowest-numbered pending node, retiring one node per accepted message.
// Assumes: load and pop never coincide.
module dhc_inval_seq #(
    parameter int NODES = 8,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NODES-1:0]  load_mask,
    input  logic              pop,
    output logic              busy,
    output logic              last,
    output logic [NODE_W-1:0] dest
);
    logic [NODES-1:0] pend;

    // Pending-set register: load a new set or retire the current node.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend <= '0;
        else if (load)
            pend <= load_mask;
        else if (pop)
            pend <= pend & ~(NODES'(1) << dest);
    end

    // Lowest pending node wins.
    always_comb begin
        dest = '0;
        for (int i = NODES - 1; i >= 0; i--)
            if (pend[i]) dest = NODE_W'(i);
    end

    assign busy = |pend;
    assign last = busy && ((pend & (pend - NODES'(1))) == '0);

    AST_POP_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> $countones(pend) == $countones($past(pend)) - 1); // R4
    AST_POP_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> busy); // R4
endmodule

// File: rtl/dir_home_ctrl.sv
// Home-node coherence controller top. Accepts one request when idle,
// reads the directory in the same cycle, then sends the response
// (writing the directory when it is taken) and any invalidates.
// Assumes: directory read data is valid combinationally from dir_rd_addr.
module dir_home_ctrl
    import dhc_pkg::*;
#(
    parameter int NODES  = 8,
    parameter int ADDR_W = 8,
    localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
    localparam int CNT_W  = NODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [NODE_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              probe_hit,
    output logic [ADDR_W-1:0] dir_rd_addr,
    input  logic [1:0]        dir_rd_state,
    input  logic [NODES-1:0]  dir_rd_sharers,
    input  logic [NODE_W-1:0] dir_rd_owner,
    output logic              dir_wr_en,
    output logic [ADDR_W-1:0] dir_wr_addr,
    output logic [1:0]        dir_wr_state,
    output logic [NODES-1:0]  dir_wr_sharers,
    output logic [NODE_W-1:0] dir_wr_owner,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [2:0]        msg_type,
    output logic [NODE_W-1:0] msg_dest,
    output logic [CNT_W-1:0]  msg_count,
    output logic [ADDR_W-1:0] msg_addr
);
    phase_e            phase;
    logic [2:0]        d_type,  c_type;
    logic [NODE_W-1:0] d_dest,  c_dest;
    logic [CNT_W-1:0]  d_count, c_count;
    logic              d_wr,    c_wr;
    logic [1:0]        d_state, c_state;
    logic [NODES-1:0]  d_sh,    c_sh;
    logic [NODES-1:0]  d_inv,   c_inv;
    logic [NODE_W-1:0] c_src;
    logic [ADDR_W-1:0] c_addr;
    logic              accept, seq_load, seq_pop, seq_busy, seq_last;
    logic [NODE_W-1:0] seq_dest;

    assign accept = req_valid && req_ready;

    dhc_decide #(.NODES(NODES)) u_decide (
        .op(req_op), .src(req_src), .st(dir_rd_state),
        .sharers(dir_rd_sharers), .owner(dir_rd_owner),
        .probe_hit(probe_hit),
        .rtype(d_type), .rdest(d_dest), .rcount(d_count),
        .wr_en(d_wr), .wr_state(d_state), .wr_sharers(d_sh),
        .inv_mask(d_inv)
    );

    assign seq_load = (phase == PH_RESP) && msg_ready;
    assign seq_pop  = (phase == PH_INV)  && msg_ready;

    dhc_inval_seq #(.NODES(NODES)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(seq_load), .load_mask(c_inv),
        .pop(seq_pop), .busy(seq_busy), .last(seq_last), .dest(seq_dest)
    );

    // Transaction phase and captured decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            c_type  <= '0;
            c_dest  <= '0;
            c_count <= '0;
            c_wr    <= 1'b0;
            c_state <= '0;
            c_sh    <= '0;
            c_inv   <= '0;
            c_src   <= '0;
            c_addr  <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (accept) begin
                    phase   <= PH_RESP;
                    c_type  <= d_type;
                    c_dest  <= d_dest;
                    c_count <= d_count;
                    c_wr    <= d_wr;
                    c_state <= d_state;
                    c_sh    <= d_sh;
                    c_inv   <= d_inv;
                    c_src   <= req_src;
                    c_addr  <= req_addr;
                end
                PH_RESP: if (msg_ready)
                    phase <= (|c_inv) ? PH_INV : PH_IDLE;
                PH_INV: if (msg_ready && seq_last)
                    phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign req_ready      = (phase == PH_IDLE);
    assign msg_valid      = (phase != PH_IDLE);
    assign msg_type       = (phase == PH_INV) ? MT_INVAL : c_type;
    assign msg_dest       = (phase == PH_INV) ? seq_dest : c_dest;
    assign msg_count      = (phase == PH_INV) ? '0 : c_count;
    assign msg_addr       = c_addr;
    assign dir_rd_addr    = req_addr;
    assign dir_wr_en      = (phase == PH_RESP) && msg_ready && c_wr;
    assign dir_wr_addr    = c_addr;
    assign dir_wr_state   = c_state;
    assign dir_wr_sharers = c_sh;
    assign dir_wr_owner   = c_src;

    AST_CLOSED_WHILE_INVALIDATING: assert property (@(posedge clk) disable iff (!rst_n)
        seq_busy |-> !req_ready); // R10
    AST_MSG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_type)
            && $stable(msg_dest) && $stable(msg_count)); // R10
    AST_NO_SELF_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_type == MT_INVAL) |-> msg_dest != c_src); // R4
    AST_EXCL_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_wr_en && dir_wr_state == DS_EXCL) |->
            ($countones(dir_wr_sharers) == 1) && dir_wr_sharers[dir_wr_owner]); // R11
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr_en |=> !dir_wr_en); // R5
    AST_NO_WRITE_ON_REFUSAL: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr_en |-> (msg_type != MT_NACK) && (msg_type != MT_UP_FAIL)); // R6, R8
endmodule

// File: tb/dir_home_ctrl_test.sv
`timescale 1ns/1ps
module dir_home_ctrl_test;
    localparam int NODES  = 8;
    localparam int ADDR_W = 4;
    localparam int NODE_W = 3;
    localparam int LINES  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_op = '0;
    logic [NODE_W-1:0] req_src = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic probe_hit = 1'b0;
    logic [ADDR_W-1:0] dir_rd_addr;
    logic [1:0] dir_rd_state;
    logic [NODES-1:0] dir_rd_sharers;
    logic [NODE_W-1:0] dir_rd_owner;
    logic dir_wr_en;
    logic [ADDR_W-1:0] dir_wr_addr;
    logic [1:0] dir_wr_state;
    logic [NODES-1:0] dir_wr_sharers;
    logic [NODE_W-1:0] dir_wr_owner;
    logic msg_valid, msg_ready = 1'b1;
    logic [2:0] msg_type;
    logic [NODE_W-1:0] msg_dest;
    logic [NODE_W:0] msg_count;
    logic [ADDR_W-1:0] msg_addr;

    always #4 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .ADDR_W(ADDR_W)) uut (.*);

    // Directory storage, written only through the port or a poke.
    logic [1:0]        mem_st [LINES];
    logic [NODES-1:0]  mem_sh [LINES];
    logic [NODE_W-1:0] mem_ow [LINES];
    logic poke_en = 1'b0;
    logic [ADDR_W-1:0] poke_a = '0;
    logic [1:0] poke_st = '0;
    logic [NODES-1:0] poke_sh = '0;
    logic [NODE_W-1:0] poke_ow = '0;
    int wr_cnt = 0;

    assign dir_rd_state   = mem_st[dir_rd_addr];
    assign dir_rd_sharers = mem_sh[dir_rd_addr];
    assign dir_rd_owner   = mem_ow[dir_rd_addr];

    always_ff @(posedge clk) begin
        if (poke_en) begin
            mem_st[poke_a] <= poke_st;
            mem_sh[poke_a] <= poke_sh;
            mem_ow[poke_a] <= poke_ow;
        end
        if (dir_wr_en) begin
            mem_st[dir_wr_addr] <= dir_wr_state;
            mem_sh[dir_wr_addr] <= dir_wr_sharers;
            mem_ow[dir_wr_addr] <= dir_wr_owner;
            wr_cnt <= wr_cnt + 1;
        end
    end

    int n_vec = 0, n_bad = 0;
    int ref_st [LINES];
    int ref_sh [LINES];
    int ref_ow [LINES];
    int e_t [16], e_d [16], e_c [16], e_n;
    int g_t [16], g_d [16], g_c [16], g_a [16], g_n;

    task automatic chk(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_line(int a, int st, int sh, int ow);
        @(negedge clk);
        poke_en = 1'b1; poke_a = ADDR_W'(a); poke_st = 2'(st);
        poke_sh = NODES'(sh); poke_ow = NODE_W'(ow);
        @(negedge clk);
        poke_en = 1'b0;
        ref_st[a] = st; ref_sh[a] = sh; ref_ow[a] = ow;
    endtask

    task automatic push(int t, int d, int c);
        e_t[e_n] = t; e_d[e_n] = d; e_c[e_n] = c; e_n++;
    endtask

    // One transaction: predict, drive, collect, compare.
    task automatic run(string req, int op, int src, int a, bit probe, bit stall);
        int st, sh, ow, k, n_st, n_sh, wr0, it;
        bit upd, prev_stall;
        int p_t, p_d, p_c;
        st = ref_st[a]; sh = ref_sh[a]; ow = ref_ow[a];
        e_n = 0; upd = 0; n_st = st; n_sh = sh;
        k = 0;
        for (int i = 0; i < NODES; i++) if (sh[i] && i != src) k++;
        if (st == 3 || op == 3) push(7, src, 0);
        else if (op == 0) begin
            upd = 1; n_st = 1;
            if (st == 2 && ow != src) begin push(4, ow, 0); n_sh = (1 << src) | (1 << ow); end
            else begin push(0, src, 0); n_sh = ((st == 1) ? sh : 0) | (1 << src); end
        end else if (op == 1) begin
            if (probe) push(7, src, 0);
            else begin
                upd = 1; n_st = 2; n_sh = 1 << src;
                if (st == 2 && ow != src) push(5, ow, 0);
                else if (st == 1) begin
                    push(1, src, k);
                    for (int i = 0; i < NODES; i++) if (sh[i] && i != src) push(6, i, 0);
                end else push(1, src, 0);
            end
        end else begin
            if (st == 1 && sh[src] && !probe) begin
                upd = 1; n_st = 2; n_sh = 1 << src;
                push(2, src, k);
                for (int i = 0; i < NODES; i++) if (sh[i] && i != src) push(6, i, 0);
            end else push(3, src, 0);
        end

        wr0 = wr_cnt;
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_src = NODE_W'(src);
        req_addr = ADDR_W'(a); probe_hit = probe;
        @(negedge clk);
        req_valid = 1'b0; probe_hit = 1'b0;
        g_n = 0; it = 0; prev_stall = 0; p_t = 0; p_d = 0; p_c = 0;
        while (!req_ready && it < 100) begin
            msg_ready = stall ? it[0] : 1'b1;
            if (prev_stall) begin
                chk("R10", "held type", int'(msg_type), p_t);
                chk("R10", "held dest", int'(msg_dest), p_d);
                chk("R10", "held count", int'(msg_count), p_c);
            end
            if (msg_valid && msg_ready && g_n < 16) begin
                g_t[g_n] = msg_type; g_d[g_n] = msg_dest;
                g_c[g_n] = msg_count; g_a[g_n] = msg_addr; g_n++;
            end
            prev_stall = msg_valid && !msg_ready;
            p_t = msg_type; p_d = msg_dest; p_c = msg_count;
            it++;
            @(negedge clk);
        end
        msg_ready = 1'b1;
        chk(req, "message count before ready", g_n, e_n);
        for (int i = 0; i < e_n && i < g_n; i++) begin
            chk(req, "msg type", g_t[i], e_t[i]);
            chk(req, "msg dest", g_d[i], e_d[i]);
            chk(req, "msg count", g_c[i], e_c[i]);
            chk(req, "msg addr", g_a[i], a);
        end
        chk(req, "directory writes", wr_cnt - wr0, upd ? 1 : 0);
        chk(req, "dir state", int'(mem_st[a]), n_st);
        chk(req, "dir sharers", int'(mem_sh[a]), n_sh);
        if (upd) chk(req, "dir owner", int'(mem_ow[a]), src);
        ref_st[a] = n_st; ref_sh[a] = n_sh; if (upd) ref_ow[a] = src;
        // R11 single holder sweep over every line
        for (int l = 0; l < LINES; l++)
            if (mem_st[l] == 2'd2) begin
                chk("R11", "exclusive holders", $countones(mem_sh[l]), 1);
                chk("R11", "holder is owner", int'(mem_sh[l][mem_ow[l]]), 1);
            end
    endtask

    task automatic t_reset;
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "msg_valid", int'(msg_valid), 0);
        chk("R1", "dir_wr_en", int'(dir_wr_en), 0);
    endtask

    task automatic t_reads;
        set_line(1, 0, 0, 0);
        run("R2", 0, 3, 1, 0, 0);
        run("R2", 0, 5, 1, 0, 1);
        set_line(2, 2, 8'h04, 2);
        run("R3", 0, 6, 2, 0, 0);
        set_line(3, 2, 8'h10, 4);
        run("R2", 0, 4, 3, 0, 0);
    endtask

    task automatic t_rdmod;
        set_line(4, 1, 8'hA5, 0);
        run("R6", 1, 5, 4, 1, 0);
        run("R4", 1, 5, 4, 0, 0);
        set_line(5, 0, 0, 0);
        run("R5", 1, 6, 5, 0, 0);
        run("R5", 1, 6, 5, 0, 0);
        run("R5", 1, 1, 5, 0, 1);
        set_line(6, 1, 8'hFF, 3);
        run("R4", 1, 0, 6, 0, 1);
    endtask

    task automatic t_upgrade;
        set_line(7, 1, 8'h1A, 0);
        run("R7", 2, 3, 7, 0, 1);
        set_line(8, 1, 8'h12, 0);
        run("R8", 2, 3, 8, 0, 0);
        run("R8", 2, 1, 8, 1, 0);
        run("R8", 2, 3, 7, 0, 0);
        set_line(9, 0, 0, 0);
        run("R8", 2, 2, 9, 0, 0);
    endtask

    task automatic t_incoherent;
        set_line(10, 3, 8'h06, 1);
        run("R9", 0, 2, 10, 0, 0);
        run("R9", 1, 2, 10, 0, 0);
        run("R9", 2, 1, 10, 0, 0);
        set_line(11, 1, 8'h03, 0);
        run("R9", 3, 0, 11, 0, 0);
    endtask

    initial begin
        for (int l = 0; l < LINES; l++) begin
            mem_st[l] = '0; mem_sh[l] = '0; mem_ow[l] = '0;
            ref_st[l] = 0; ref_sh[l] = 0; ref_ow[l] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_rdmod();
        t_upgrade();
        t_incoherent();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog: actual hung expected idle");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule